// File: doc/BRIEF.md
# Locking Hardware Error Capture Unit

This unit collects diagnostic details about hardware faults seen at a processor's bus interface and keeps them for software to read. It holds two capture groups that work independently of each other. The bus group takes error reports from external transactions: acknowledgements from the system that report correctable or uncorrectable errors, transactions ended by a hard-error acknowledgement, and parity errors found in the address or control field of an external cache tag probe. The fill group takes data errors detected while filling the primary cache: parity, single-bit and double-bit EDC. A snapshot of the tag probe result is shared by both groups.

The first legal error a group sees loads its status bits and its payload into the group and locks it. A locked group keeps that content until software writes its unlock strobe. A later error still raises its notification: a level corrected-read interrupt that stays up until acknowledged, or a single-cycle machine-check pulse that is gated by an enable. A later uncorrectable error on a locked group sets that group's sticky fatal bit, which shows that its details were dropped. Tag parity errors also tell the lookup logic in the same cycle that the transaction must miss the external cache.

Top module: `err_capture_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, every status, address, command, syndrome and tag output is zero, and `crd_irq`, `mchk_pulse` are low.
- R2: Bus kind codes are 0 correctable ack, 1 uncorrectable ack, 2 hard-error termination, 3 tag address parity, 4 tag control parity. A bus event on an unlocked group, sampled at a rising edge, sets `bus_status[kind]` alone, sets the lock bit `bus_status[6]`, and loads `bus_addr` and `bus_cmd` from the payload. These values are visible after that edge.
- R3: While the bus group is locked and no unlock is written, later bus events leave `bus_status[4:0]`, `bus_addr` and `bus_cmd` unchanged.
- R4: A bus event of kind 1 to 4 on a locked bus group sets the sticky fatal bit `bus_status[5]`. A kind 0 event on a locked group does not set it.
- R5: Fill kind codes are 0 parity, 1 single-bit, 2 double-bit. The first fill event sets `fill_status[kind]` and the lock bit `fill_status[4]`, and loads `fill_addr` and `fill_syn`. While the fill group is locked these stay frozen. A kind 0 or 2 event on a locked fill group sets the fatal bit `fill_status[3]`.
- R6: An unlock write clears the lock bit and the fatal bit of its own group only. The captured status kind bits, address and payload remain readable.
- R7: An unlock write and a new event in the same cycle capture the new event. The group relocks with its fatal bit clear.
- R8: A correctable event (bus kind 0 or fill kind 1), locked group or not, sets `crd_irq` after the edge. `crd_irq` holds until a cycle with `crd_ack` and no new correctable event clears it.
- R9: An uncorrectable event (bus kinds 1 to 4, fill kinds 0 and 2) sampled with `mchk_en` high gives exactly one cycle of `mchk_pulse` after that edge, even on a locked group. With `mchk_en` low there is no pulse.
- R10: `tag_snap` loads `probe_tag` when a group captures, but only if neither group stays locked through that edge. Otherwise it holds.
- R11: `tag_force_miss` is high, combinationally, exactly while `bus_err_vld` is high with kind 3 or 4.
- R12: Bus kinds 5 to 7 and fill kind 3 are ignored: no capture, no fatal, no interrupt and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mchk_en | input | 1 | Machine-check enable |
| bus_err_vld | input | 1 | Bus error event strobe |
| bus_err_kind | input | 3 | Bus error kind code |
| bus_err_addr | input | ADDR_W | Address of failing transaction |
| bus_err_cmd | input | 3 | Bus command code of failing transaction |
| probe_tag | input | TAG_W | Current external cache tag probe result |
| fill_err_vld | input | 1 | Fill error event strobe |
| fill_err_kind | input | 2 | Fill error kind code |
| fill_err_addr | input | ADDR_W | Fill address |
| fill_err_syn | input | SYN_W | Fill EDC syndrome |
| bus_unlock_wr | input | 1 | Software write unlocking the bus group |
| fill_unlock_wr | input | 1 | Software write unlocking the fill group |
| crd_ack | input | 1 | Software acknowledge of corrected-read interrupt |
| bus_status | output | 7 | {lock, fatal, tag ctl par, tag addr par, hard, uncorr ack, corr ack} |
| bus_addr | output | ADDR_W | Captured bus address |
| bus_cmd | output | 3 | Captured bus command |
| fill_status | output | 5 | {lock, fatal, double-bit, single-bit, parity} |
| fill_addr | output | ADDR_W | Captured fill address |
| fill_syn | output | SYN_W | Captured fill syndrome |
| tag_snap | output | TAG_W | Shared tag probe snapshot |
| tag_force_miss | output | 1 | Force external cache miss on tag parity error |
| crd_irq | output | 1 | Corrected-read interrupt level |
| mchk_pulse | output | 1 | Machine-check pulse |

## Verification
The capture path is driven with every bus and fill kind code, first on an unlocked group and then on a locked one. This separates a fresh capture from a frozen one, and a correctable late event from an uncorrectable one that must set fatal. Unlock writes are issued alone, to both groups at once, and together with a new event. These patterns show that an unlock touches only its own group and that a same-cycle capture wins. The machine-check enable is toggled between uncorrectable events, and the acknowledge is given both with and without a coincident correctable event. Illegal kind codes and the combinational miss signal are probed between clock edges.

// File: rtl/errcap_pkg.sv
// Shared kind encodings and derived widths for the error capture unit.
package errcap_pkg;
    typedef enum logic [2:0] {
        BK_CORR   = 3'd0,
        BK_UNCORR = 3'd1,
        BK_HARD   = 3'd2,
        BK_TADDR  = 3'd3,
        BK_TCTL   = 3'd4
    } bus_kind_e;

    typedef enum logic [1:0] {
        FK_PAR = 2'd0,
        FK_SBE = 2'd1,
        FK_DBE = 2'd2
    } fill_kind_e;

    localparam int CMD_W       = 3;
    localparam int BUS_CLS_W   = 5;
    localparam int FILL_CLS_W  = 3;
    localparam int BUS_STAT_W  = BUS_CLS_W + 2;
    localparam int FILL_STAT_W = FILL_CLS_W + 2;
endpackage

// File: rtl/errcap_group.sv
// One locking capture group. It loads class bits and payload on the first
// event while unlocked, then freezes until unlock_wr. A later uncorrectable
// event sets the sticky fatal bit. Assumes evt_vld is already qualified to
// legal kinds and evt_cls is one-hot.
module errcap_group #(
    parameter int CLS_W = 5,
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_vld,
    input  logic [CLS_W-1:0] evt_cls,
    input  logic             evt_uncorr,
    input  logic [PAY_W-1:0] evt_pay,
    input  logic             unlock_wr,
    output logic [CLS_W-1:0] cls_q,
    output logic [PAY_W-1:0] pay_q,
    output logic             locked_q,
    output logic             fatal_q,
    output logic             cap_o,
    output logic             hold_o
);
    // Lock that survives this edge, and capture when the group is open.
    always_comb begin
        hold_o = locked_q & ~unlock_wr;
        cap_o  = evt_vld & ~hold_o;
    end

    // Capture, unlock or fatal update of the group registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q    <= '0;
            pay_q    <= '0;
            locked_q <= 1'b0;
            fatal_q  <= 1'b0;
        end else if (cap_o) begin
            cls_q    <= evt_cls;
            pay_q    <= evt_pay;
            locked_q <= 1'b1;
            fatal_q  <= 1'b0;
        end else if (unlock_wr) begin
            locked_q <= 1'b0;
            fatal_q  <= 1'b0;
        end else if (evt_vld && evt_uncorr) begin
            fatal_q  <= 1'b1;
        end
    end
endmodule

// File: rtl/errcap_tag_hold.sv
// Shared tag probe snapshot. It loads on a capture only when no group keeps
// its lock through the edge.
module errcap_tag_hold #(
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TAG_W-1:0] tag_in,
    output logic [TAG_W-1:0] tag_q
);
    // Snapshot register.
    always_ff @(posedge clk) begin
        if (!rst_n)    tag_q <= '0;
        else if (load) tag_q <= tag_in;
    end
endmodule

// File: rtl/errcap_notify.sv
// Notification outputs. The corrected-read interrupt is a level held until
// acknowledged, and a new event wins over the ack. The machine check is a
// one-cycle pulse per cycle with an enabled uncorrectable event.
module errcap_notify (
    input  logic clk,
    input  logic rst_n,
    input  logic corr_evt,
    input  logic uncorr_evt,
    input  logic mchk_en,
    input  logic crd_ack,
    output logic crd_irq,
    output logic mchk_pulse
);
    // Interrupt level and machine-check pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crd_irq    <= 1'b0;
            mchk_pulse <= 1'b0;
        end else begin
            if (corr_evt)     crd_irq <= 1'b1;
            else if (crd_ack) crd_irq <= 1'b0;
            mchk_pulse <= uncorr_evt & mchk_en;
        end
    end
endmodule

// File: rtl/err_capture_unit.sv
// Top of the locking hardware error capture unit. It decodes the bus and fill
// kind codes, feeds the two capture groups, the shared tag snapshot and the
// notifier. Assumes at most one bus and one fill event per cycle.
module err_capture_unit
    import errcap_pkg::*;
#(
    parameter int ADDR_W = 34,
    parameter int SYN_W  = 8,
    parameter int TAG_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mchk_en,
    input  logic                   bus_err_vld,
    input  logic [2:0]             bus_err_kind,
    input  logic [ADDR_W-1:0]      bus_err_addr,
    input  logic [CMD_W-1:0]       bus_err_cmd,
    input  logic [TAG_W-1:0]       probe_tag,
    input  logic                   fill_err_vld,
    input  logic [1:0]             fill_err_kind,
    input  logic [ADDR_W-1:0]      fill_err_addr,
    input  logic [SYN_W-1:0]       fill_err_syn,
    input  logic                   bus_unlock_wr,
    input  logic                   fill_unlock_wr,
    input  logic                   crd_ack,
    output logic [BUS_STAT_W-1:0]  bus_status,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [CMD_W-1:0]       bus_cmd,
    output logic [FILL_STAT_W-1:0] fill_status,
    output logic [ADDR_W-1:0]      fill_addr,
    output logic [SYN_W-1:0]       fill_syn,
    output logic [TAG_W-1:0]       tag_snap,
    output logic                   tag_force_miss,
    output logic                   crd_irq,
    output logic                   mchk_pulse
);
    localparam int BUS_PAY_W  = CMD_W + ADDR_W;
    localparam int FILL_PAY_W = SYN_W + ADDR_W;

    logic [BUS_CLS_W-1:0]  bus_cls;
    logic                  bus_legal, bus_unc, bus_cor;
    logic [FILL_CLS_W-1:0] fill_cls;
    logic                  fill_legal, fill_unc, fill_cor;

    // Bus kind decode into a one-hot class and a correctability flag.
    always_comb begin
        bus_cls   = '0;
        bus_legal = 1'b1;
        bus_unc   = 1'b1;
        case (bus_err_kind)
            BK_CORR:   begin bus_cls[0] = 1'b1; bus_unc = 1'b0; end
            BK_UNCORR: bus_cls[1] = 1'b1;
            BK_HARD:   bus_cls[2] = 1'b1;
            BK_TADDR:  bus_cls[3] = 1'b1;
            BK_TCTL:   bus_cls[4] = 1'b1;
            default:   begin bus_legal = 1'b0; bus_unc = 1'b0; end
        endcase
        bus_cor        = bus_err_vld & bus_legal & ~bus_unc;
        tag_force_miss = bus_err_vld & (bus_cls[3] | bus_cls[4]);
    end

    // Fill kind decode into a one-hot class and a correctability flag.
    always_comb begin
        fill_cls   = '0;
        fill_legal = 1'b1;
        fill_unc   = 1'b1;
        case (fill_err_kind)
            FK_PAR:  fill_cls[0] = 1'b1;
            FK_SBE:  begin fill_cls[1] = 1'b1; fill_unc = 1'b0; end
            FK_DBE:  fill_cls[2] = 1'b1;
            default: begin fill_legal = 1'b0; fill_unc = 1'b0; end
        endcase
        fill_cor = fill_err_vld & fill_legal & ~fill_unc;
    end

    logic                  bus_ev, fill_ev;
    logic [BUS_CLS_W-1:0]  bus_cls_q;
    logic [BUS_PAY_W-1:0]  bus_pay_q;
    logic                  bus_lk, bus_ft, bus_cap, bus_hold;
    logic [FILL_CLS_W-1:0] fill_cls_q;
    logic [FILL_PAY_W-1:0] fill_pay_q;
    logic                  fill_lk, fill_ft, fill_cap, fill_hold;

    assign bus_ev  = bus_err_vld & bus_legal;
    assign fill_ev = fill_err_vld & fill_legal;

    errcap_group #(.CLS_W(BUS_CLS_W), .PAY_W(BUS_PAY_W)) u_bus_grp (
        .clk(clk), .rst_n(rst_n),
        .evt_vld(bus_ev), .evt_cls(bus_cls), .evt_uncorr(bus_unc),
        .evt_pay({bus_err_cmd, bus_err_addr}), .unlock_wr(bus_unlock_wr),
        .cls_q(bus_cls_q), .pay_q(bus_pay_q), .locked_q(bus_lk),
        .fatal_q(bus_ft), .cap_o(bus_cap), .hold_o(bus_hold)
    );

    errcap_group #(.CLS_W(FILL_CLS_W), .PAY_W(FILL_PAY_W)) u_fill_grp (
        .clk(clk), .rst_n(rst_n),
        .evt_vld(fill_ev), .evt_cls(fill_cls), .evt_uncorr(fill_unc),
        .evt_pay({fill_err_syn, fill_err_addr}), .unlock_wr(fill_unlock_wr),
        .cls_q(fill_cls_q), .pay_q(fill_pay_q), .locked_q(fill_lk),
        .fatal_q(fill_ft), .cap_o(fill_cap), .hold_o(fill_hold)
    );

    errcap_tag_hold #(.TAG_W(TAG_W)) u_tag (
        .clk(clk), .rst_n(rst_n),
        .load((bus_cap | fill_cap) & ~(bus_hold | fill_hold)),
        .tag_in(probe_tag), .tag_q(tag_snap)
    );

    errcap_notify u_ntf (
        .clk(clk), .rst_n(rst_n),
        .corr_evt(bus_cor | fill_cor),
        .uncorr_evt((bus_err_vld & bus_unc) | (fill_err_vld & fill_unc)),
        .mchk_en(mchk_en), .crd_ack(crd_ack),
        .crd_irq(crd_irq), .mchk_pulse(mchk_pulse)
    );

    // Register views assembled for software.
    always_comb begin
        bus_status  = {bus_lk, bus_ft, bus_cls_q};
        bus_addr    = bus_pay_q[ADDR_W-1:0];
        bus_cmd     = bus_pay_q[BUS_PAY_W-1:ADDR_W];
        fill_status = {fill_lk, fill_ft, fill_cls_q};
        fill_addr   = fill_pay_q[ADDR_W-1:0];
        fill_syn    = fill_pay_q[FILL_PAY_W-1:ADDR_W];
    end
endmodule

// File: rtl/errcap_checker.sv
// Port-level properties of err_capture_unit, attached by bind below.
module errcap_checker #(
    parameter int ADDR_W = 34,
    parameter int SYN_W  = 8,
    parameter int TAG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mchk_en,
    input logic              bus_err_vld,
    input logic              bus_unlock_wr,
    input logic              fill_unlock_wr,
    input logic              crd_ack,
    input logic [6:0]        bus_status,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2:0]        bus_cmd,
    input logic [4:0]        fill_status,
    input logic [ADDR_W-1:0] fill_addr,
    input logic [SYN_W-1:0]  fill_syn,
    input logic [TAG_W-1:0]  tag_snap,
    input logic              tag_force_miss,
    input logic              crd_irq,
    input logic              mchk_pulse
);
    AST_BUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_status[6] && !bus_unlock_wr |=> $stable(bus_addr) && $stable(bus_cmd) && $stable(bus_status[4:0])); // R3
    AST_BUS_FATAL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_status[5]) |-> $past(bus_status[6])); // R4
    AST_FILL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        fill_status[4] && !fill_unlock_wr |=> $stable(fill_addr) && $stable(fill_syn)); // R5
    AST_UNLOCK_OWN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        fill_unlock_wr && !bus_unlock_wr && bus_status[6] |=> bus_status[6]); // R6
    AST_CRD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        crd_irq && !crd_ack |=> crd_irq); // R8
    AST_MCHK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_pulse |-> $past(mchk_en)); // R9
    AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_status[6] && !bus_unlock_wr |=> $stable(tag_snap)); // R10
    AST_MISS_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        tag_force_miss |-> bus_err_vld); // R11
endmodule

bind err_capture_unit errcap_checker #(
    .ADDR_W(ADDR_W), .SYN_W(SYN_W), .TAG_W(TAG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mchk_en(mchk_en), .bus_err_vld(bus_err_vld),
    .bus_unlock_wr(bus_unlock_wr), .fill_unlock_wr(fill_unlock_wr),
    .crd_ack(crd_ack), .bus_status(bus_status), .bus_addr(bus_addr),
    .bus_cmd(bus_cmd), .fill_status(fill_status), .fill_addr(fill_addr),
    .fill_syn(fill_syn), .tag_snap(tag_snap), .tag_force_miss(tag_force_miss),
    .crd_irq(crd_irq), .mchk_pulse(mchk_pulse)
);

// File: tb/tb_err_capture_unit.sv
`timescale 1ns/1ps
module tb_err_capture_unit;
    localparam int ADDR_W = 34;
    localparam int SYN_W  = 8;
    localparam int TAG_W  = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n, mchk_en, bus_err_vld, fill_err_vld;
    logic [2:0]        bus_err_kind, bus_err_cmd, bus_cmd;
    logic [ADDR_W-1:0] bus_err_addr, fill_err_addr, bus_addr, fill_addr;
    logic [TAG_W-1:0]  probe_tag, tag_snap;
    logic [1:0]        fill_err_kind;
    logic [SYN_W-1:0]  fill_err_syn, fill_syn;
    logic              bus_unlock_wr, fill_unlock_wr, crd_ack;
    logic [6:0]        bus_status;
    logic [4:0]        fill_status;
    logic              tag_force_miss, crd_irq, mchk_pulse;

    err_capture_unit #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .TAG_W(TAG_W)) dut (
        .clk(clk), .rst_n(rst_n), .mchk_en(mchk_en),
        .bus_err_vld(bus_err_vld), .bus_err_kind(bus_err_kind),
        .bus_err_addr(bus_err_addr), .bus_err_cmd(bus_err_cmd),
        .probe_tag(probe_tag), .fill_err_vld(fill_err_vld),
        .fill_err_kind(fill_err_kind), .fill_err_addr(fill_err_addr),
        .fill_err_syn(fill_err_syn), .bus_unlock_wr(bus_unlock_wr),
        .fill_unlock_wr(fill_unlock_wr), .crd_ack(crd_ack),
        .bus_status(bus_status), .bus_addr(bus_addr), .bus_cmd(bus_cmd),
        .fill_status(fill_status), .fill_addr(fill_addr), .fill_syn(fill_syn),
        .tag_snap(tag_snap), .tag_force_miss(tag_force_miss),
        .crd_irq(crd_irq), .mchk_pulse(mchk_pulse)
    );

    typedef struct packed {
        logic        bv; logic [2:0] bk; logic [15:0] ba; logic [2:0] bc;
        logic        fv; logic [1:0] fk; logic [15:0] fa; logic [7:0] fs;
        logic        bu; logic fu; logic me; logic ack; logic [15:0] tag;
        logic [6:0]  e_bs; logic [15:0] e_ba; logic [2:0] e_bc;
        logic [4:0]  e_fs; logic [15:0] e_fa; logic [7:0] e_fsyn;
        logic        e_crd; logic e_mc; logic [15:0] e_tag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R2 R8 R10: first correctable bus ack captures and raises interrupt
        '{1,0,16'h1111,1, 0,0,16'h0,8'h0, 0,0,1,0,16'h00A1, 7'h41,16'h1111,1, 5'h00,16'h0,8'h0, 1,0,16'h00A1},
        // R3 R4 R9: uncorrectable on locked group, fatal and pulse, no overwrite
        '{1,1,16'h2222,2, 0,0,16'h0,8'h0, 0,0,1,0,16'h00A2, 7'h61,16'h1111,1, 5'h00,16'h0,8'h0, 1,1,16'h00A1},
        // R5 R8 R10: fill single-bit capture; ack with new event keeps irq
        '{0,0,16'h0,0, 1,1,16'h3333,8'h5A, 0,0,1,1,16'h00A3, 7'h61,16'h1111,1, 5'h12,16'h3333,8'h5A, 1,0,16'h00A1},
        // R8: ack alone clears interrupt
        '{0,0,16'h0,0, 0,0,16'h0,8'h0, 0,0,0,1,16'h0, 7'h61,16'h1111,1, 5'h12,16'h3333,8'h5A, 0,0,16'h00A1},
        // R6: bus unlock clears only bus lock and fatal
        '{0,0,16'h0,0, 0,0,16'h0,8'h0, 1,0,0,0,16'h0, 7'h01,16'h1111,1, 5'h12,16'h3333,8'h5A, 0,0,16'h00A1},
        // R2 R9 R10: hard error with enable low, tag held by fill lock
        '{1,2,16'h4444,6, 0,0,16'h0,8'h0, 0,0,0,0,16'h00A5, 7'h44,16'h4444,6, 5'h12,16'h3333,8'h5A, 0,0,16'h00A1},
        // R5 R9: double-bit fill on locked group sets fill fatal
        '{0,0,16'h0,0, 1,2,16'h5555,8'h77, 0,0,1,0,16'h0, 7'h44,16'h4444,6, 5'h1A,16'h3333,8'h5A, 0,1,16'h00A1},
        // R6: both unlocks together
        '{0,0,16'h0,0, 0,0,16'h0,8'h0, 1,1,0,0,16'h0, 7'h04,16'h4444,6, 5'h02,16'h3333,8'h5A, 0,0,16'h00A1},
        // R2 R10: tag address parity, tag loads
        '{1,3,16'h6666,3, 0,0,16'h0,8'h0, 0,0,1,0,16'h00A8, 7'h48,16'h6666,3, 5'h02,16'h3333,8'h5A, 0,1,16'h00A8},
        // R7 R10: unlock plus tag control parity in one cycle relocks
        '{1,4,16'h7777,4, 0,0,16'h0,8'h0, 1,0,1,0,16'h00A9, 7'h50,16'h7777,4, 5'h02,16'h3333,8'h5A, 0,1,16'h00A9},
        // R12: illegal bus kind ignored
        '{1,5,16'h8888,5, 0,0,16'h0,8'h0, 0,0,1,0,16'h0, 7'h50,16'h7777,4, 5'h02,16'h3333,8'h5A, 0,0,16'h00A9},
        // R12: illegal fill kind ignored
        '{0,0,16'h0,0, 1,3,16'hAAAA,8'h33, 0,0,1,0,16'h0, 7'h50,16'h7777,4, 5'h02,16'h3333,8'h5A, 0,0,16'h00A9},
        // R5 R9 R10: fill parity captures, tag held by bus lock
        '{0,0,16'h0,0, 1,0,16'h9999,8'h11, 0,0,1,0,16'h00AC, 7'h50,16'h7777,4, 5'h11,16'h9999,8'h11, 0,1,16'h00A9}
    };

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        bus_err_vld = 0; bus_err_kind = 0; bus_err_addr = '0; bus_err_cmd = 0;
        fill_err_vld = 0; fill_err_kind = 0; fill_err_addr = '0; fill_err_syn = '0;
        bus_unlock_wr = 0; fill_unlock_wr = 0; crd_ack = 0; mchk_en = 0; probe_tag = '0;
    endtask

    task automatic check_cleared(input string tag);
        chk({tag, " bus_status"}, 64'(bus_status), 0);
        chk({tag, " bus_addr"}, 64'(bus_addr), 0);
        chk({tag, " fill_status"}, 64'(fill_status), 0);
        chk({tag, " fill_addr"}, 64'(fill_addr), 0);
        chk({tag, " tag_snap"}, 64'(tag_snap), 0);
        chk({tag, " irq/mchk"}, 64'({crd_irq, mchk_pulse}), 0);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_cleared("R1 in reset");
        rst_n = 1;
        @(negedge clk);
        check_cleared("R1 after reset");

        for (int i = 0; i < NV; i++) begin
            bus_err_vld = VECS[i].bv; bus_err_kind = VECS[i].bk;
            bus_err_addr = ADDR_W'(VECS[i].ba); bus_err_cmd = VECS[i].bc;
            fill_err_vld = VECS[i].fv; fill_err_kind = VECS[i].fk;
            fill_err_addr = ADDR_W'(VECS[i].fa); fill_err_syn = VECS[i].fs;
            bus_unlock_wr = VECS[i].bu; fill_unlock_wr = VECS[i].fu;
            mchk_en = VECS[i].me; crd_ack = VECS[i].ack; probe_tag = VECS[i].tag;
            @(posedge clk);
            @(negedge clk);
            idle();
            chk($sformatf("R2 R3 R4 R6 R7 bus_status v%0d", i), 64'(bus_status), 64'(VECS[i].e_bs));
            chk($sformatf("R2 R3 bus_addr v%0d", i), 64'(bus_addr), 64'(VECS[i].e_ba));
            chk($sformatf("R2 R3 bus_cmd v%0d", i), 64'(bus_cmd), 64'(VECS[i].e_bc));
            chk($sformatf("R5 R6 R12 fill_status v%0d", i), 64'(fill_status), 64'(VECS[i].e_fs));
            chk($sformatf("R5 fill_addr v%0d", i), 64'(fill_addr), 64'(VECS[i].e_fa));
            chk($sformatf("R5 fill_syn v%0d", i), 64'(fill_syn), 64'(VECS[i].e_fsyn));
            chk($sformatf("R8 crd_irq v%0d", i), 64'(crd_irq), 64'(VECS[i].e_crd));
            chk($sformatf("R9 R12 mchk_pulse v%0d", i), 64'(mchk_pulse), 64'(VECS[i].e_mc));
            chk($sformatf("R10 tag_snap v%0d", i), 64'(tag_snap), 64'(VECS[i].e_tag));
        end

        // R9: the pulse lasts one cycle only
        @(negedge clk);
        chk("R9 pulse single cycle", 64'(mchk_pulse), 0);

        // R11: combinational miss request, probed between edges
        bus_err_vld = 1; bus_err_kind = 3; #0.5;
        chk("R11 miss on tag addr parity", 64'(tag_force_miss), 1);
        bus_err_kind = 4; #0.5;
        chk("R11 miss on tag ctl parity", 64'(tag_force_miss), 1);
        bus_err_kind = 2; #0.5;
        chk("R11 no miss on hard error", 64'(tag_force_miss), 0);
        bus_err_vld = 0; bus_err_kind = 3; #0.5;
        chk("R11 no miss without strobe", 64'(tag_force_miss), 0);
        idle();

        // R1: reset mid-run clears everything
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        check_cleared("R1 reset mid-run");
        rst_n = 1;

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule